// File: doc/BRIEF.md
# Programmable Reed-Solomon Parity Encoder

This block turns a byte stream into systematic Reed-Solomon codewords over GF(256). Each block enters as K message bytes followed by R placeholder bytes. In encode mode the placeholders leave the block as the remainder of the message polynomial divided by the code generator. In pass-through mode every byte, placeholders included, leaves unchanged. One byte is accepted per clock with no stall, and each accepted byte appears on the output one cycle later. The first check byte therefore follows the last message byte with no gap.

Setup travels over the same 8-bit data input. After reset the first six valid bytes form a configuration record. That record gives the parity length R, the message length K, the total length N and a mode bit. Data is processed only once a consistent record has been taken. A synchronous reset drops the configuration, and a new record must then be loaded.

The field is built on x^8 + x^7 + x^2 + x + 1. The generator has R consecutive roots, starting at alpha^120 where alpha = 0x02. R may be any even value from 2 to 20, so between 1 and 10 byte errors can be corrected per block.

Top module: `rs_parity_encoder`

## Requirements
- R1: After reset, the first six bytes with `in_valid` high form the configuration record, in this order: two ignored bytes, R, K, N, then the mode byte (bit 0 = 1 for encode, 0 for pass-through). `cfg_done` rises in the cycle after the sixth byte is taken when the record is accepted, and it stays high until reset.
- R2: While `cfg_done` is low, every valid byte is taken as configuration. No byte reaches the output and `out_valid` stays low.
- R3: The record is rejected when R is odd, below 2 or above 20, when K is 0, or when N differs from K + R. A rejected record sets `cfg_err`, leaves `cfg_done` low, and the next six valid bytes start a fresh record. An accepted record clears `cfg_err`.
- R4: Reset (`rst` high at a clock edge) leaves `cfg_done`, `cfg_err` and `out_valid` low in the following cycle.
- R5: Once configured, a byte with `in_valid` high is emitted on `out_data` with `out_valid` high exactly one cycle later. In encode mode the K message bytes are emitted unchanged.
- R6: In encode mode the R placeholder bytes are replaced by the remainder of m(x)·x^R mod g(x), with the highest-degree coefficient first. The first message byte is the highest-degree message coefficient. The field polynomial is 0x187 and g(x) = prod (x + alpha^i) for i = 120 .. 119+R. Every emitted codeword therefore evaluates to zero at each of those roots.
- R7: In pass-through mode all N bytes of a block, placeholders included, are emitted unchanged.
- R8: A valid byte with `in_sof` high is position 0 of a new block. Any block in progress is abandoned and its partial parity is discarded.
- R9: A valid byte that arrives after the N-th byte of a block and carries no `in_sof` is dropped, and no output follows it.
- R10: A new block may start in the cycle right after the previous block's last placeholder, and both blocks come out correct with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the configuration |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_sof | input | 1 | Marks the valid byte as the first byte of a block |
| in_data | input | 8 | Configuration or block byte |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | 8 | Message, parity or passed-through byte |
| cfg_done | output | 1 | A consistent configuration record is loaded |
| cfg_err | output | 1 | The last complete record was inconsistent |

## Verification
The hardest collision is a block start that arrives in the cycle right after the previous block's last placeholder. In that cycle the output register still carries the final check byte of the old block, while the parity register must restart from zero for the new one. The bench provokes this by streaming two blocks with `in_valid` held high throughout. It judges both codewords against a polynomial long-division model and checks that each evaluates to zero at every generator root. A second collision, a start strobe in the middle of a block, is provoked after a seven-byte fragment. There the bench expects only the restarted block's codeword to be correct.

// File: rtl/rse_pkg.sv
package rse_pkg;
    localparam int SYM_W    = 8;
    localparam int MAX_R    = 20;
    localparam int MAX_T    = MAX_R / 2;
    localparam int R_W      = $clog2(MAX_R + 1);
    localparam int CFG_LEN  = 6;
    localparam int CNT_W    = $clog2(CFG_LEN);
    localparam int ROOT_EXP = 120;
    localparam logic [SYM_W-1:0] POLY_LOW = 8'h87;  // x^8 = x^7 + x^2 + x + 1

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [MAX_R-1:0][SYM_W-1:0] gen_row_t;
    typedef logic [MAX_T:0][MAX_R-1:0][SYM_W-1:0] gen_tab_t;

    typedef enum logic [1:0] {SLOT_NONE, SLOT_MSG, SLOT_PAR} slot_e;

    typedef struct packed {
        logic [R_W-1:0] r;
        sym_t           k;
        sym_t           n;
        logic           enc;
    } cfg_t;

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc = '0;
        sym_t sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[SYM_W-1] ? ({sh[SYM_W-2:0], 1'b0} ^ POLY_LOW) : {sh[SYM_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    // Low-order generator coefficients (monic term implied) for every even R.
    function automatic gen_tab_t build_gen();
        gen_tab_t tab = '0;
        sym_t     c [MAX_R+1];
        sym_t     base = 8'h01;
        sym_t     root;
        for (int e = 0; e < ROOT_EXP; e++) base = gf_mul(base, 8'h02);
        for (int t = 1; t <= MAX_T; t++) begin
            for (int i = 0; i <= MAX_R; i++) c[i] = '0;
            c[0] = 8'h01;
            root = base;
            for (int j = 0; j < 2 * t; j++) begin
                for (int i = j + 1; i > 0; i--) c[i] = c[i-1] ^ gf_mul(c[i], root);
                c[0] = gf_mul(c[0], root);
                root = gf_mul(root, 8'h02);
            end
            for (int i = 0; i < 2 * t; i++) tab[t][i] = c[i];
        end
        return tab;
    endfunction

    localparam gen_tab_t GEN_TAB = build_gen();
endpackage

// File: rtl/rse_cfg.sv
module rse_cfg
    import rse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  sym_t din,
    output cfg_t cfg,
    output logic done,
    output logic err
);
    logic [CNT_W-1:0] cnt;
    sym_t r_st, k_st, n_st;
    logic rec_ok;

    always_comb begin
        rec_ok = (r_st[0] == 1'b0) && (r_st >= SYM_W'(2)) && (r_st <= SYM_W'(MAX_R))
              && (k_st != '0)
              && (({1'b0, k_st} + {1'b0, r_st}) == {1'b0, n_st});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            r_st <= '0;
            k_st <= '0;
            n_st <= '0;
            cfg  <= '0;
            done <= 1'b0;
            err  <= 1'b0;
        end else if (load) begin
            if (cnt == CNT_W'(CFG_LEN - 1)) begin
                cnt <= '0;
                done <= rec_ok;
                err  <= !rec_ok;
                cfg  <= '{r: r_st[R_W-1:0], k: k_st, n: n_st, enc: din[0]};
            end else begin
                cnt <= cnt + 1'b1;
                case (cnt)
                    CNT_W'(2): r_st <= din;
                    CNT_W'(3): k_st <= din;
                    CNT_W'(4): n_st <= din;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rse_seq.sv
module rse_seq
    import rse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  act,
    input  logic  sof,
    input  sym_t  k,
    input  sym_t  n,
    output slot_e slot
);
    sym_t pos;
    logic in_blk;
    sym_t idx;
    logic live;
    logic [SYM_W:0] nxt;

    always_comb begin
        idx  = sof ? '0 : pos;
        live = act && (sof || in_blk);
        nxt  = {1'b0, idx} + 1'b1;
        if (!live)        slot = SLOT_NONE;
        else if (idx < k) slot = SLOT_MSG;
        else              slot = SLOT_PAR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            in_blk <= 1'b0;
        end else if (live) begin
            pos    <= nxt[SYM_W-1:0];
            in_blk <= nxt < {1'b0, n};
        end
    end
endmodule

// File: rtl/rse_lfsr.sv
module rse_lfsr
    import rse_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic           clear,
    input  logic           is_msg,
    input  sym_t           din,
    input  logic [R_W-1:0] r_sel,
    input  gen_row_t       coef,
    output sym_t           par_top
);
    gen_row_t p_q, p_eff, p_sh, p_nxt;
    sym_t     top_eff, fb;

    assign p_eff = clear ? '0 : p_q;
    assign p_sh  = {p_eff[MAX_R-2:0], {SYM_W{1'b0}}};

    always_comb begin
        top_eff = '0;
        for (int i = 0; i < MAX_R; i++)
            if (i == int'(r_sel) - 1) top_eff = p_eff[i];
    end

    assign fb      = din ^ top_eff;
    assign par_top = top_eff;

    for (genvar i = 0; i < MAX_R; i++) begin : g_stage
        localparam logic [R_W-1:0] IDX = R_W'(i);
        assign p_nxt[i] = (IDX < r_sel)
                        ? (is_msg ? (p_sh[i] ^ gf_mul(fb, coef[i])) : p_sh[i])
                        : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)       p_q <= '0;
        else if (step) p_q <= p_nxt;
    end
endmodule

// File: rtl/rs_parity_encoder.sv
module rs_parity_encoder
    import rse_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [SYM_W-1:0] in_data,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             cfg_done,
    output logic             cfg_err
);
    cfg_t     cfg_q;
    slot_e    slot;
    gen_row_t coef;
    sym_t     par_top;
    logic     step;

    rse_cfg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid && !cfg_done),
        .din  (in_data),
        .cfg  (cfg_q),
        .done (cfg_done),
        .err  (cfg_err)
    );

    rse_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .act  (in_valid && cfg_done),
        .sof  (in_sof),
        .k    (cfg_q.k),
        .n    (cfg_q.n),
        .slot (slot)
    );

    assign step = (slot != SLOT_NONE);
    assign coef = GEN_TAB[cfg_q.r[R_W-1:1]];

    rse_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .clear   (step && in_sof),
        .is_msg  (slot == SLOT_MSG),
        .din     (in_data),
        .r_sel   (cfg_q.r),
        .coef    (coef),
        .par_top (par_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= step;
            out_data  <= (slot == SLOT_PAR && cfg_q.enc) ? par_top : in_data;
        end
    end
endmodule

// File: rtl/rse_chk.sv
module rse_chk
    import rse_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  in_valid,
    input sym_t  in_data,
    input logic  out_valid,
    input sym_t  out_data,
    input logic  cfg_done,
    input logic  cfg_err,
    input logic  enc,
    input slot_e slot
);
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);

    p_quiet_unconfigured_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(cfg_done) && $past(in_valid)));

    p_err_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(cfg_done && cfg_err));

    p_reset_clears_r4: assert property (@(posedge clk)
        rst |=> (!cfg_done && !cfg_err && !out_valid));

    p_msg_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_MSG) |=> (out_valid && out_data == $past(in_data)));

    p_pass_copy_r7: assert property (@(posedge clk) disable iff (rst)
        (slot != SLOT_NONE && !enc) |=> (out_valid && out_data == $past(in_data)));

    p_drop_stray_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_done && slot == SLOT_NONE) |=> !out_valid);
endmodule

bind rs_parity_encoder rse_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .cfg_done  (cfg_done),
    .cfg_err   (cfg_err),
    .enc       (cfg_q.enc),
    .slot      (slot)
);

// File: tb/sim_rs_parity_encoder.sv
module sim_rs_parity_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic [7:0] out_data;
    logic       cfg_done;
    logic       cfg_err;

    rs_parity_encoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .cfg_done(cfg_done), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] sbuf [0:1023];
    logic [7:0] cap  [0:1023];
    int ncap = 0;

    always @(negedge clk) begin
        if (out_valid) begin
            if (ncap < 1024) cap[ncap] = out_data;
            ncap++;
        end
    end

    // row: R, K, encode, seed
    typedef struct packed {
        logic [7:0] r;
        logic [7:0] k;
        logic       enc;
        logic [7:0] seed;
    } row_t;
    localparam row_t ROWS [7] = '{
        '{8'd2,  8'd1,   1'b1, 8'h3C},
        '{8'd20, 8'd235, 1'b1, 8'h71},
        '{8'd4,  8'd10,  1'b1, 8'h05},
        '{8'd16, 8'd50,  1'b0, 8'hA2},
        '{8'd10, 8'd20,  1'b1, 8'h9E},
        '{8'd6,  8'd100, 1'b1, 8'h00},
        '{8'd8,  8'd30,  1'b0, 8'h44}
    };

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bmul(int a, int b);
        int p = 0;
        while (b != 0) begin
            if (b & 1) p = p ^ a;
            a = a << 1;
            if (a & 256) a = a ^ 'h187;
            b = b >> 1;
        end
        return p;
    endfunction

    function automatic int bpow(int e);
        int v = 1;
        for (int i = 0; i < e; i++) v = bmul(v, 2);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk); in_valid = 0; in_sof = 0; rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic send_byte(logic [7:0] d, logic sof);
        @(negedge clk);
        in_valid = 1; in_sof = sof; in_data = d;
    endtask

    task automatic idle(int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            in_valid = 0; in_sof = 0;
        end
    endtask

    task automatic configure(int r, int k, int n, int enc);
        send_byte(8'hA5, 0); send_byte(8'h5A, 1);
        send_byte(8'(r), 0); send_byte(8'(k), 0);
        send_byte(8'(n), 0); send_byte(8'(enc), 0);
        idle(1);
    endtask

    task automatic put_block(int off, int r, int k, int seed);
        for (int i = 0; i < k; i++) sbuf[off+i] = 8'((seed * 7 + i * 29 + ((i * i) >> 3)) & 255);
        for (int i = 0; i < r; i++) sbuf[off+k+i] = 8'(8'hC3 ^ i);
    endtask

    task automatic send_range(int off, int len);
        for (int i = 0; i < len; i++) send_byte(sbuf[off+i], i == 0);
    endtask

    task automatic check_cw(int cb, int ioff, int r, int k, int enc, string tag);
        int n = k + r;
        int w [0:255];
        int gh [0:20];
        int bad_m = 0, bad_p = 0, bad_s = 0, root;
        for (int i = 0; i <= 20; i++) gh[i] = 0;
        gh[0] = 1;
        for (int j = 0; j < r; j++) begin
            root = bpow(120 + j);
            for (int i = j + 1; i > 0; i--) gh[i] = gh[i] ^ bmul(gh[i-1], root);
        end
        for (int i = 0; i < n; i++) w[i] = (i < k) ? int'(sbuf[ioff+i]) : 0;
        for (int i = 0; i < k; i++)
            if (w[i] != 0) begin
                int c = w[i];
                for (int j = 1; j <= r; j++) w[i+j] = w[i+j] ^ bmul(c, gh[j]);
            end
        for (int i = 0; i < k; i++) if (cap[cb+i] != sbuf[ioff+i]) bad_m++;
        for (int i = k; i < n; i++) begin
            int e = enc ? w[i] : int'(sbuf[ioff+i]);
            if (int'(cap[cb+i]) != e) bad_p++;
        end
        if (enc) begin
            chk(bad_m == 0, "R5", {tag, " message bytes mismatching"}, bad_m, 0);
            chk(bad_p == 0, "R6", {tag, " check bytes mismatching"}, bad_p, 0);
            for (int j = 0; j < r; j++) begin
                int s = 0;
                root = bpow(120 + j);
                for (int i = 0; i < n; i++) s = bmul(s, root) ^ int'(cap[cb+i]);
                if (s != 0) bad_s++;
            end
            chk(bad_s == 0, "R6", {tag, " nonzero syndromes"}, bad_s, 0);
        end else begin
            chk(bad_m + bad_p == 0, "R7", {tag, " bytes altered in pass-through"}, bad_m + bad_p, 0);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        do_reset();
        @(negedge clk);
        // R4: reset state
        chk(!cfg_done && !cfg_err && !out_valid, "R4", "outputs after reset",
            int'({cfg_done, cfg_err, out_valid}), 0);

        // Vector table walk
        for (int v = 0; v < 7; v++) begin
            int r = int'(ROWS[v].r), k = int'(ROWS[v].k);
            do_reset();
            configure(r, k, r + k, int'(ROWS[v].enc));
            chk(cfg_done == 1'b1, "R1", $sformatf("row %0d cfg_done", v), int'(cfg_done), 1);
            put_block(0, r, k, int'(ROWS[v].seed));
            base = ncap;
            send_range(0, r + k);
            idle(3);
            chk(ncap - base == r + k, ROWS[v].enc ? "R5" : "R7",
                $sformatf("row %0d output count", v), ncap - base, r + k);
            check_cw(base, 0, r, k, int'(ROWS[v].enc), $sformatf("row %0d", v));
        end

        // R1/R2: partial record does not configure, nothing emitted
        do_reset();
        base = ncap;
        send_byte(8'h00, 0); send_byte(8'h00, 1); send_byte(8'd4, 0);
        send_byte(8'd10, 0); send_byte(8'd14, 0);
        idle(2);
        chk(cfg_done == 1'b0, "R1", "cfg_done after five bytes", int'(cfg_done), 0);
        send_byte(8'h01, 0);
        idle(1);
        chk(cfg_done == 1'b1, "R1", "cfg_done after sixth byte", int'(cfg_done), 1);
        idle(2);
        chk(ncap == base, "R2", "outputs during configuration", ncap - base, 0);

        // R3: inconsistent records
        do_reset();
        configure(4, 10, 15, 1);
        chk(cfg_err && !cfg_done, "R3", "N != K+R flags", int'({cfg_err, cfg_done}), 2);
        base = ncap;
        send_byte(8'h11, 1); idle(2);
        chk(ncap == base, "R2", "block while rejected", ncap - base, 0);
        do_reset();
        configure(5, 10, 15, 1);
        chk(cfg_err && !cfg_done, "R3", "odd R flags", int'({cfg_err, cfg_done}), 2);
        configure(22, 10, 32, 1);
        chk(cfg_err && !cfg_done, "R3", "R above 20 flags", int'({cfg_err, cfg_done}), 2);
        configure(4, 10, 14, 1);
        chk(!cfg_err && cfg_done, "R3", "fresh record accepted", int'({cfg_err, cfg_done}), 1);

        // R4: reset drops configuration, following block ignored
        do_reset();
        idle(1);
        chk(!cfg_done && !cfg_err, "R4", "configuration cleared", int'({cfg_done, cfg_err}), 0);

        // R8: restart in mid-block
        do_reset();
        configure(6, 20, 26, 1);
        put_block(0, 6, 20, 17);
        put_block(100, 6, 20, 90);
        base = ncap;
        send_range(0, 7);
        send_range(100, 26);
        idle(3);
        chk(ncap - base == 33, "R8", "outputs for fragment plus block", ncap - base, 33);
        check_cw(base + 7, 100, 6, 20, 1, "R8 restarted block");

        // R9: stray bytes after a finished block
        base = ncap;
        send_byte(8'h12, 0); send_byte(8'h34, 0); send_byte(8'h56, 0); send_byte(8'h78, 0);
        idle(3);
        chk(ncap == base, "R9", "outputs for stray bytes", ncap - base, 0);

        // R10: back-to-back blocks, no idle between them
        do_reset();
        configure(4, 10, 14, 1);
        put_block(0, 4, 10, 201);
        put_block(14, 4, 10, 58);
        base = ncap;
        send_range(0, 14);
        send_range(14, 14);
        idle(3);
        chk(ncap - base == 28, "R10", "outputs for two blocks", ncap - base, 28);
        check_cw(base, 0, 4, 10, 1, "R10 first block");
        check_cw(base + 14, 14, 4, 10, 1, "R10 second block");

        finished = 1;
        summary();
        $finish;
    end
endmodule